// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block merges edge-triggered interrupt requests from two 8-bit general-purpose I/O ports onto one shared request line. Each pin has an enable bit and a polarity bit. A polarity of 1 arms the pin for a rising edge, and a polarity of 0 arms it for a falling edge. Pin levels pass through a two-flop synchronizer before edge detection. When an armed, enabled pin sees its edge, the block sends a one-cycle pulse to the interrupt controller. No pin number is reported, so firmware reads the ports to find the source.

After a pulse, the triggering pin or pins hold a lockout. While the lockout is held, edges on every other pin are dropped. The lockout ends when each holder has returned to its non-trigger level or has had its enable cleared. The acknowledge from the interrupt controller is accepted but changes nothing: it does not clear enables and it does not end the lockout. Enable and polarity bits are written one port at a time over a small write-only register bus.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset `irq_o` is low and every enable and polarity bit is 0, so no pin activity raises a request.
- R2: On an enabled pin with polarity 1, a rising edge raises `irq_o` for exactly one cycle, at the third rising clock edge after the pin changes (two synchronizer stages plus the output register).
- R3: On an enabled pin with polarity 0, a falling edge raises `irq_o` with the same one-cycle width and the same three-cycle latency.
- R4: A pin whose enable bit is 0 never raises a request, on either edge.
- R5: All pins drive the single `irq_o`. Several pins triggering in the same cycle give one pulse, and every one of those pins holds the lockout until all of them are inactive or disabled. No pin is favoured over another.
- R6: While the lockout is held, triggering edges on other pins raise no request and are not remembered for later.
- R7: The lockout ends when its holder returns to its non-trigger level (low for polarity 1, high for polarity 0). A triggering edge that reaches the detector in the cycle after the release raises a request.
- R8: Clearing the enable bit of the pin that holds the lockout releases the lockout on the next clock.
- R9: `irq_ack` changes neither the enable bits nor the lockout.
- R10: In `reg_addr`, bit 1 selects the bank (0 = enable, 1 = polarity) and bit 0 selects the port. Bit b of `reg_wdata` maps to pin b of that port, which is `pins_i[port*8+b]`. A write to one bank leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 16 | Raw pin levels, port 1 in the upper byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Bank select (bit 1) and port select (bit 0) |
| reg_wdata | input | 8 | Per-pin bits for the selected bank and port |
| irq_ack | input | 1 | Acknowledge from the interrupt controller |
| irq_o | output | 1 | One-cycle shared interrupt request |

## Verification
The hardest conditions to reach are the precise end of a lockout: the cycle in which the holder goes inactive or loses its enable, and a new edge arriving just as the lockout clears. The stimulus times a second pin's edge so that it reaches the detector in the first cycle after the release. A release that came one cycle late would therefore drop that edge, and the missing pulse shows up at the output. Lockout under simultaneous triggers is reached by dropping two pins in the same cycle. One of them is then released alone while a third pin is edged, and that third pin must stay silent.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PORTS   = 2;
    localparam int PORT_W      = 8;
    localparam int NPINS       = NUM_PORTS * PORT_W;
    localparam int PORT_SEL_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int ADDR_W      = PORT_SEL_W + 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        BANK_ENABLE   = 1'b0,
        BANK_POLARITY = 1'b1
    } bank_e;

    // Per-pin configuration as seen by the detector and the lockout logic.
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] pol;
    } pin_cfg_t;

    // Per-pin view after synchronization.
    typedef struct packed {
        logic [NPINS-1:0] edge_hit;   // armed edge seen this cycle
        logic [NPINS-1:0] at_level;   // pin sits at its trigger level
    } pin_view_t;

    function automatic logic pick_edge(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

    function automatic logic pick_level(input logic pol, input logic lvl);
        return pol ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output pin_cfg_t          cfg
);

    bank_e                 bank;
    logic [PORT_SEL_W-1:0] port_sel;
    logic [PORT_W-1:0]     en_bank  [NUM_PORTS];
    logic [PORT_W-1:0]     pol_bank [NUM_PORTS];
    logic [NPINS-1:0]      en_flat;
    logic [NPINS-1:0]      pol_flat;

    assign bank     = bank_e'(addr[ADDR_W-1]);
    assign port_sel = addr[PORT_SEL_W-1:0];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = we && (port_sel == PORT_SEL_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_bank[p]  <= '0;
                pol_bank[p] <= '0;
            end else if (hit) begin
                case (bank)
                    BANK_ENABLE:   en_bank[p]  <= wdata;
                    BANK_POLARITY: pol_bank[p] <= wdata;
                    default: ;
                endcase
            end
        end

        assign en_flat[p*PORT_W +: PORT_W]  = en_bank[p];
        assign pol_flat[p*PORT_W +: PORT_W] = pol_bank[p];
    end

    assign cfg = '{en: en_flat, pol: pol_flat};

    AST_BANK_ISOLATION: assert property (@(posedge clk) disable iff (rst)
        (we && bank == BANK_ENABLE) |=> $stable(cfg.pol)); // R10

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_i,
    input  logic [NPINS-1:0] pol,
    output pin_view_t        view
);

    logic [NPINS-1:0] hit_v;
    logic [NPINS-1:0] lvl_v;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;
        logic                   cur;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pins_i[i]};
                prev_q <= sync_q[SYNC_STAGES-1];
            end
        end

        assign cur      = sync_q[SYNC_STAGES-1];
        assign hit_v[i] = pick_edge(pol[i], cur & ~prev_q, ~cur & prev_q);
        assign lvl_v[i] = pick_level(pol[i], cur);
    end

    assign view = '{edge_hit: hit_v, at_level: lvl_v};

endmodule

// File: rtl/gpio_irq_lock.sv
module gpio_irq_lock
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pin_cfg_t         cfg,
    input  pin_view_t        view,
    output logic             irq_o,
    output logic [NPINS-1:0] holders
);

    logic [NPINS-1:0] cand;
    logic [NPINS-1:0] live;
    logic             free;

    assign cand = view.edge_hit & cfg.en;
    assign live = holders & cfg.en & view.at_level;
    assign free = (holders == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            holders <= '0;
            irq_o   <= 1'b0;
        end else begin
            irq_o <= free && (cand != '0);
            if (free) begin
                holders <= cand;
            end else if (live == '0) begin
                holders <= '0;
            end
        end
    end

    AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R2

    AST_PULSE_TAKES_LOCK: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (holders != '0)); // R5

    AST_HELD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (holders != '0 && live != '0) |=> !irq_o); // R6

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (holders != '0 && (holders & cfg.en) == '0) |=> (holders == '0)); // R8

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PORT_W-1:0] reg_wdata,
    input  logic              irq_ack,
    output logic              irq_o
);

    pin_cfg_t         cfg;
    pin_view_t        view;
    logic [NPINS-1:0] holders;

    gpio_irq_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    gpio_irq_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .pol    (cfg.pol),
        .view   (view)
    );

    gpio_irq_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .view    (view),
        .irq_o   (irq_o),
        .holders (holders)
    );

    // The acknowledge path deliberately reaches no state.
    AST_ACK_KEEPS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !reg_we) |=> $stable(cfg.en)); // R9

    AST_ACK_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && (holders & cfg.en & view.at_level) != '0 && !reg_we) |=> (holders != '0)); // R9

endmodule

// File: tb/tb_gpio_irq_agg.sv
`timescale 1ns/1ps
module tb_gpio_irq_agg;
    import gpio_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NPINS-1:0]  pins = '0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [PORT_W-1:0] wdata = '0;
    logic              ack = 1'b0;
    logic              irq;

    gpio_irq_agg dut (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pins),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .irq_ack   (ack),
        .irq_o     (irq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    want_low = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a pulse appears.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (want_low) begin
                    chk(irq == 1'b0, "R2", "pulse width (cycle after pulse)", int'(irq), 0);
                    want_low = 1'b0;
                end
                if (irq) begin : pop
                    int    e;
                    string t;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6", "unexpected pulse at cycle", cyc, -1);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(cyc == e, t, "pulse cycle", cyc, e);
                        want_low = 1'b1;
                    end
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: changes one pin and, if a pulse is due, queues its cycle.
    task automatic set_pin(input int i, input logic v, input bit expect_irq, input string tag);
        pins[i] = v;
        if (expect_irq) begin
            exp_q.push_back(cyc + 3);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [PORT_W-1:0] d);
        we = 1'b1;
        addr = a;
        wdata = d;
        step(1);
        we = 1'b0;
    endtask

    task automatic drained(input string tag);
        step(6);
        chk(exp_q.size() == 0, tag, "missing pulses", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        step(3);
        chk(irq == 1'b0, "R1", "irq during reset", int'(irq), 0);
        rst = 1'b0;
        step(1);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);

        // R1: nothing enabled yet, edges of both kinds are silent
        set_pin(0, 1'b1, 1'b0, "R1");
        step(3);
        set_pin(0, 1'b0, 1'b0, "R1");
        set_pin(9, 1'b1, 1'b0, "R1");
        step(3);
        set_pin(9, 1'b0, 1'b0, "R1");
        drained("R1");

        // Setup: pin0 rising, all others falling, idle levels
        wr(2'b10, 8'h01);
        wr(2'b11, 8'h00);
        for (int i = 1; i < NPINS; i++) pins[i] = 1'b1;
        step(4);
        wr(2'b00, 8'hFF);
        wr(2'b01, 8'hFF);
        step(2);

        // R2: rising edge on polarity-1 pin
        set_pin(0, 1'b1, 1'b1, "R2");
        drained("R2");
        set_pin(0, 1'b0, 1'b0, "R2");
        step(4);

        // R3: falling edge on polarity-0 pin of port 1
        set_pin(9, 1'b0, 1'b1, "R3");
        step(5);
        // R6: holder pin9 still low, other edges dropped
        set_pin(10, 1'b0, 1'b0, "R6");
        step(2);
        set_pin(0, 1'b1, 1'b0, "R6");
        drained("R6");

        // R7: release by returning to inactive level, edge right after
        set_pin(9, 1'b1, 1'b0, "R7");
        step(1);
        set_pin(11, 1'b0, 1'b1, "R7");
        drained("R7");
        set_pin(11, 1'b1, 1'b0, "R7");
        set_pin(10, 1'b1, 1'b0, "R7");
        set_pin(0, 1'b0, 1'b0, "R7");
        step(4);

        // R5: simultaneous triggers, both hold the lockout
        set_pin(3, 1'b0, 1'b1, "R5");
        set_pin(12, 1'b0, 1'b0, "R5");
        step(5);
        set_pin(3, 1'b1, 1'b0, "R5");
        step(4);
        set_pin(4, 1'b0, 1'b0, "R5");
        drained("R5");
        set_pin(12, 1'b1, 1'b0, "R5");
        step(1);
        set_pin(5, 1'b0, 1'b1, "R5");
        drained("R5");
        set_pin(4, 1'b1, 1'b0, "R5");
        set_pin(5, 1'b1, 1'b0, "R5");
        step(4);

        // R8: disabling the holder releases on the next clock
        set_pin(6, 1'b0, 1'b1, "R8");
        step(5);
        wr(2'b00, 8'hBF);
        set_pin(7, 1'b0, 1'b1, "R8");
        drained("R8");
        set_pin(7, 1'b1, 1'b0, "R8");
        set_pin(6, 1'b1, 1'b0, "R8");
        wr(2'b00, 8'hFF);
        step(4);

        // R10: enable writes left pin0 polarity intact
        set_pin(0, 1'b1, 1'b1, "R10");
        drained("R10");
        set_pin(0, 1'b0, 1'b0, "R10");
        step(4);

        // R9: acknowledge leaves lockout and enables untouched
        set_pin(13, 1'b0, 1'b1, "R9");
        step(4);
        ack = 1'b1;
        step(2);
        ack = 1'b0;
        set_pin(14, 1'b0, 1'b0, "R9");
        step(4);
        drained("R9");
        set_pin(13, 1'b1, 1'b0, "R9");
        step(1);
        set_pin(15, 1'b0, 1'b1, "R9");
        drained("R9");
        set_pin(14, 1'b1, 1'b0, "R9");
        set_pin(15, 1'b1, 1'b0, "R9");
        step(4);

        // R4: disabled pins silent on both edges
        wr(2'b01, 8'h00);
        set_pin(8, 1'b0, 1'b0, "R4");
        step(4);
        set_pin(8, 1'b1, 1'b0, "R4");
        step(2);
        set_pin(10, 1'b0, 1'b0, "R4");
        drained("R4");
        set_pin(10, 1'b1, 1'b0, "R4");
        step(4);

        // R10: polarity write to port 1 bit 0 reaches pins_i[8]
        wr(2'b11, 8'h01);
        wr(2'b01, 8'h01);
        step(2);
        set_pin(8, 1'b0, 1'b0, "R10");
        drained("R10");
        set_pin(8, 1'b1, 1'b1, "R10");
        drained("R10");

        summary();
        $finish;
    end

endmodule